// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block sits beside a byte-wide Ethernet receive path while the MAC is parked in a low-power wake mode. Once armed, it scans every received frame for the wake pattern. The pattern is a run of six 0xFF bytes followed directly by sixteen copies of the local 48-bit station address, and it may start at any byte offset in the frame. While armed, the block suppresses every frame toward the normal receive path, whether or not the frame matches.

A frame wakes the system only if three things hold at its last byte: the pattern was seen in full, the frame check sequence was reported good, and the upstream address filter accepted the destination. When that happens, the block clears its own enable bit and sets a sticky event flag. The flag, gated by a mask bit, drives the interrupt line. Software arms the block with a configuration write, can disarm it at any time without producing an event, and clears the event by writing one to it.

Top module: `wol_magic_detect`

## Requirements
- R1: After reset the enable, the event flag and the interrupt output are all 0.
- R2: A frame carrying the full pattern (six 0xFF bytes, then sixteen copies of the address with station_addr[47:40] sent first and station_addr[7:0] last), at any offset, that ends with rx_fcs_ok=1 and rx_addr_ok=1 while armed clears wake_en and sets wake_evt on the clock edge that takes the end-of-frame byte.
- R3: If rx_fcs_ok or rx_addr_ok is 0 on the end-of-frame byte, a frame that matches the pattern raises no event and leaves the block armed.
- R4: A pattern that is broken by a wrong byte, cut short by the end of the frame, or split across two frames raises no event.
- R5: A run of more than six 0xFF bytes before the address copies still counts as a valid pattern start.
- R6: A frame whose start byte arrives while wake_en is 1 is held off the forward path for its whole length (fwd_valid stays 0), even if wake_en falls during that frame.
- R7: A frame that starts while wake_en is 0 is forwarded unchanged: fwd_valid, fwd_sof, fwd_eof and fwd_data follow the rx inputs in the same cycle.
- R8: A configuration write with cfg_en_in=0 disarms the block at once. Any pattern in progress then raises no event.
- R9: wake_evt stays set until a cycle with evt_clr=1. If a wake and a clear fall in the same cycle, the wake wins.
- R10: wake_irq equals wake_evt AND the mask bit, and the mask bit is loaded from cfg_mask_in on each configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_fcs_ok | input | 1 | Frame check sequence good, valid with rx_eof |
| rx_addr_ok | input | 1 | Destination accepted by address filter, valid with rx_eof |
| station_addr | input | 48 | Local station address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en_in | input | 1 | Enable value written |
| cfg_mask_in | input | 1 | Interrupt mask value written |
| evt_clr | input | 1 | Write-one-to-clear for the event flag |
| wake_en | output | 1 | Wake mode armed |
| wake_evt | output | 1 | Sticky wake event |
| wake_irq | output | 1 | Masked wake interrupt |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_sof | output | 1 | Forwarded start of frame |
| fwd_eof | output | 1 | Forwarded end of frame |
| fwd_data | output | 8 | Forwarded byte |

## Verification
The forward outputs are combinational from the rx inputs, so the bench samples them one time unit after it drives each byte, inside the same cycle. wake_en and wake_evt change on the edge that takes the end-of-frame byte, so the bench checks them at the falling edge that follows, exactly one edge after the last drive. Configuration writes and clears also act after one edge, and their results are read at the next falling edge. The expected values come from a whole-frame substring search and a register model in the bench, updated once per frame.

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int PREFIX_LEN  = 6,
  parameter int ADDR_COPIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_fcs_ok,
  input  logic        rx_addr_ok,
  input  logic [47:0] station_addr,
  input  logic        cfg_wr,
  input  logic        cfg_en_in,
  input  logic        cfg_mask_in,
  input  logic        evt_clr,
  output logic        wake_en,
  output logic        wake_evt,
  output logic        wake_irq,
  output logic        fwd_valid,
  output logic        fwd_sof,
  output logic        fwd_eof,
  output logic [7:0]  fwd_data
);
  localparam int PAT_LEN = PREFIX_LEN + 6 * ADDR_COPIES;
  localparam int CW      = $clog2(PAT_LEN + 1);
  localparam logic [CW-1:0] LAST_POS = CW'(PAT_LEN - 1);
  localparam logic [CW-1:0] PRE_POS  = CW'(PREFIX_LEN);

  logic [CW-1:0] pos_q, pos_b;
  logic [2:0]    sidx_q, sidx_b;
  logic          found_q, found_b;
  logic          en_q, mask_q, evt_q, drop_q;
  logic [7:0]    addr_byte, exp_byte;
  logic          byte_ok, hit, wake, drop_now;

  assign pos_b   = rx_sof ? '0 : pos_q;
  assign sidx_b  = rx_sof ? '0 : sidx_q;
  assign found_b = rx_sof ? 1'b0 : found_q;

  always_comb begin
    case (sidx_b)
      3'd0:    addr_byte = station_addr[47:40];
      3'd1:    addr_byte = station_addr[39:32];
      3'd2:    addr_byte = station_addr[31:24];
      3'd3:    addr_byte = station_addr[23:16];
      3'd4:    addr_byte = station_addr[15:8];
      default: addr_byte = station_addr[7:0];
    endcase
  end

  assign exp_byte = (pos_b < PRE_POS) ? 8'hFF : addr_byte;
  assign byte_ok  = (rx_data == exp_byte);
  assign hit      = rx_valid && byte_ok && (pos_b == LAST_POS);
  assign wake     = en_q && rx_valid && rx_eof && (found_b || hit) && rx_fcs_ok && rx_addr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pos_q   <= '0;
      sidx_q  <= '0;
      found_q <= 1'b0;
    end else if (rx_valid) begin
      if (rx_eof) begin
        pos_q   <= '0;
        sidx_q  <= '0;
        found_q <= 1'b0;
      end else if (hit) begin
        pos_q   <= '0;
        sidx_q  <= '0;
        found_q <= 1'b1;
      end else if (byte_ok) begin
        pos_q   <= pos_b + 1'b1;
        sidx_q  <= (pos_b < PRE_POS || sidx_b == 3'd5) ? 3'd0 : sidx_b + 3'd1;
        found_q <= found_b;
      end else begin
        if (rx_data == 8'hFF)
          pos_q <= (pos_b == PRE_POS) ? PRE_POS : CW'(1);
        else
          pos_q <= '0;
        sidx_q  <= '0;
        found_q <= found_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      evt_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (wake)        en_q <= 1'b0;
      else if (cfg_wr) en_q <= cfg_en_in;
      if (cfg_wr) mask_q <= cfg_mask_in;
      if (wake)         evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
      if (rx_valid && rx_sof) drop_q <= en_q;
    end
  end

  assign drop_now  = rx_sof ? en_q : drop_q;
  assign fwd_valid = rx_valid && !drop_now;
  assign fwd_sof   = fwd_valid && rx_sof;
  assign fwd_eof   = fwd_valid && rx_eof;
  assign fwd_data  = rx_data;

  assign wake_en  = en_q;
  assign wake_evt = evt_q;
  assign wake_irq = evt_q && mask_q;
endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_sof,
  input logic cfg_wr,
  input logic cfg_en_in,
  input logic evt_clr,
  input logic wake_en,
  input logic wake_evt,
  input logic wake_irq,
  input logic fwd_valid
);
  // R10
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> wake_evt);

  // R2
  evt_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> (!wake_en && $past(wake_en)));

  // R6
  armed_sof_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && wake_en) |-> !fwd_valid);

  // R9
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !evt_clr) |=> wake_evt);

  // R8
  arm_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_en) |-> $past(cfg_wr && cfg_en_in));
endmodule

bind wol_magic_detect wol_magic_detect_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .cfg_wr(cfg_wr), .cfg_en_in(cfg_en_in), .evt_clr(evt_clr),
  .wake_en(wake_en), .wake_evt(wake_evt), .wake_irq(wake_irq),
  .fwd_valid(fwd_valid)
);

// File: tb/test_wol_magic_detect.sv
module test_wol_magic_detect;
  localparam int CLK_PERIOD = 10;
  localparam int PAT_LEN = 102;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_fcs_ok = 0, rx_addr_ok = 0;
  logic [7:0] rx_data = 0;
  logic [47:0] station_addr = 48'h112233445566;
  logic cfg_wr = 0, cfg_en_in = 0, cfg_mask_in = 0, evt_clr = 0;
  logic wake_en, wake_evt, wake_irq, fwd_valid, fwd_sof, fwd_eof;
  logic [7:0] fwd_data;

  int checks = 0, errors = 0;
  logic [7:0] frm [0:255];
  bit en_m = 0, evt_m = 0, mask_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wol_magic_detect i_wol_magic_detect (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_byte(int k);
    if (k < 6) return 8'hFF;
    return station_addr[8*(5 - (k - 6) % 6) +: 8];
  endfunction

  function automatic bit has_pattern(int len);
    for (int off = 0; off + PAT_LEN <= len; off++) begin
      bit ok = 1;
      for (int k = 0; k < PAT_LEN; k++)
        if (frm[off + k] != pat_byte(k)) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  task automatic fill_random(int len);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom_range(0, 254));
  endtask

  task automatic put_pattern(int off);
    for (int k = 0; k < PAT_LEN; k++) frm[off + k] = pat_byte(k);
  endtask

  task automatic cfg_write(bit en, bit mask);
    @(negedge clk); cfg_wr = 1; cfg_en_in = en; cfg_mask_in = mask;
    @(negedge clk); cfg_wr = 0;
    en_m = en; mask_m = mask;
  endtask

  task automatic clear_evt();
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
    evt_m = 0;
  endtask

  task automatic check_regs(string req);
    check({req, " enable"}, wake_en, en_m);
    check({req, " event"}, wake_evt, evt_m);
    check({req, " irq"}, wake_irq, evt_m & mask_m);
  endtask

  // abort_at >= 0 issues a disarm write on that byte
  task automatic send_frame(string req, int len, bit fcs, bit aok, int abort_at);
    int fwd_cnt = 0, mism = 0;
    bit armed_sof = en_m;
    bit found = has_pattern(len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = frm[i]; rx_fcs_ok = fcs; rx_addr_ok = aok;
      if (i == abort_at) begin cfg_wr = 1; cfg_en_in = 0; cfg_mask_in = mask_m; end
      else cfg_wr = 0;
      #1;
      if (fwd_valid) begin
        fwd_cnt++;
        if (fwd_data != frm[i] || fwd_sof != (i == 0) || fwd_eof != (i == len - 1)) mism++;
      end
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; cfg_wr = 0;
    if (abort_at >= 0 && abort_at < len) en_m = 0;
    else if (en_m && found && fcs && aok) begin en_m = 0; evt_m = 1; end
    check_regs(req);
    check({req, " R6/R7 forwarded bytes"}, fwd_cnt, armed_sof ? 0 : len);
    check({req, " R7 forwarded content"}, mism, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check_regs("R1 reset");

    // R7 disarmed forwarding
    fill_random(40); send_frame("R7 disarmed", 40, 1, 1, -1);

    // R2 pattern mid-frame, R10 masked irq off
    cfg_write(1, 0);
    fill_random(150); put_pattern(23); send_frame("R2 offset 23", 150, 1, 1, -1);
    cfg_write(0, 1); check_regs("R10 mask set");
    // R9 clear
    clear_evt(); check_regs("R9 w1c");

    // R3 bad fcs, bad address
    cfg_write(1, 1);
    fill_random(120); put_pattern(0); send_frame("R3 fcs bad", 120, 0, 1, -1);
    send_frame("R3 addr bad", 120, 1, 0, -1);

    // R4 broken pattern, truncated, split
    fill_random(130); put_pattern(10); frm[70] = 8'h00; send_frame("R4 broken", 130, 1, 1, -1);
    fill_random(80); put_pattern(10 - 10 + 0); send_frame("R4 truncated", 80, 1, 1, -1);
    fill_random(60); for (int k = 0; k < 60; k++) frm[k] = pat_byte(k);
    send_frame("R4 split a", 60, 1, 1, -1);
    for (int k = 0; k < 42; k++) frm[k] = pat_byte(60 + k);
    send_frame("R4 split b", 42, 1, 1, -1);

    // R5 long 0xFF run, pattern ending on eof
    fill_random(112); for (int k = 0; k < 4; k++) frm[6 + k] = 8'hFF;
    put_pattern(10); send_frame("R5 long ff run", 112, 1, 1, -1);
    clear_evt();

    // R8 abort mid-frame, frame still dropped (R6)
    cfg_write(1, 1);
    fill_random(140); put_pattern(20); send_frame("R8 abort", 140, 1, 1, 50);

    // R9 wake and clear same cycle
    cfg_write(1, 1);
    fill_random(110); put_pattern(8);
    for (int i = 0; i < 110; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == 109);
      rx_data = frm[i]; rx_fcs_ok = 1; rx_addr_ok = 1; evt_clr = (i == 109);
    end
    @(negedge clk); rx_valid = 0; rx_eof = 0; evt_clr = 0;
    en_m = 0; evt_m = 1;
    check_regs("R9 set beats clear");
    clear_evt();

    // random frames
    for (int n = 0; n < 80; n++) begin
      int len = $urandom_range(20, 200);
      if (!en_m && $urandom_range(0, 3) != 0) cfg_write(1, 1'($urandom_range(0, 1)));
      if (evt_m && $urandom_range(0, 1) == 1) clear_evt();
      fill_random(len);
      if (len >= PAT_LEN && $urandom_range(0, 1) == 1) begin
        put_pattern($urandom_range(0, len - PAT_LEN));
        if ($urandom_range(0, 3) == 0) frm[$urandom_range(0, len - 1)] = 8'h5A;
      end
      send_frame("R2 random", len, 1'($urandom_range(0, 4) != 0),
                 1'($urandom_range(0, 4) != 0), -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule